// File: doc/BRIEF.md
# Half-Precision to 8-bit Float Narrowing Converter

This block narrows one IEEE half-precision operand into an 8-bit floating-point byte. A select input chooses one of two byte layouts. The narrow-exponent layout has 1 sign, 4 exponent and 3 fraction bits. The wide-exponent layout has 1 sign, 5 exponent and 2 fraction bits. The caller chooses between two ways of rounding. In the default way, the block rounds to the nearest representable value and breaks ties toward an even fraction. In the other way, the block adds a caller-supplied random byte to the bits it is about to drop and then truncates, which gives stochastic rounding. A separate saturate flag makes overflow clamp to the largest finite value instead of producing infinity.

Each operand is first sorted into one of five input classes: ZERO, SUB (subnormal), NORM, INF and NAN. A per-layout narrowing lane then handles the operand according to its class, under a `unique case`. Both lanes are built from one parameterised module. The selected lane's magnitude is joined with the input sign and held in a single output register. Results are therefore produced at a rate of one per clock, with one clock of latency. There are no transitions between classes: each operand is classified on its own, in the cycle it is presented.

Top module: `fp16_to_fp8_cvt`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle in which `in_valid` was high and `rst_n` was high. A low `rst_n`, sampled at a rising edge, clears `out_valid` on that edge.
- R2: With `fmt_sel`=0 (4-bit exponent, bias 7, byte `s eeee fff`) and `stoch_en`=0, a finite input that is in range is rounded to the nearest representable value, with ties going to an even fraction LSB. For example, 1.0 gives 0x38.
- R3: With `fmt_sel`=1 (5-bit exponent, bias 15, byte `s eeeee ff`) and `stoch_en`=0, a finite input that is in range is rounded to the nearest value, with ties going to even. For example, 1.0 gives 0x3C.
- R4: Subnormal inputs and subnormal results (exponent field 0, value = fraction × 2^(1−bias−fraction width)) are converted exactly as by the rounding rule in force. A magnitude that rounds below the smallest subnormal gives a signed zero.
- R5: With `stoch_en`=1, `in_bias` is added to the dropped bits, with its MSB aligned to the first dropped bit, and the sum is truncated. A carry out of this addition adds one unit in the last place, and that may raise the exponent. A bias of 0 truncates toward zero.
- R6: With `sat_en`=0, a finite input whose rounded magnitude exceeds the layout maximum (240 in layout 0, 57344 in layout 1) gives infinity: magnitude 0x78 in layout 0, 0x7C in layout 1.
- R7: With `sat_en`=1, such an overflow gives the largest finite magnitude instead: 0x77 in layout 0, 0x7B in layout 1.
- R8: An infinite input gives infinity when `sat_en`=0 and the largest finite magnitude when `sat_en`=1.
- R9: A NaN input gives a quiet NaN whatever `sat_en` is set to. The magnitude is 0x7C in layout 0 and 0x7E in layout 1.
- R10: Bit 7 of every result equals the sign of the input, including for zeros, NaN and clamped values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_half | input | 16 | Half-precision operand |
| in_bias | input | 8 | Random byte used in stochastic mode |
| fmt_sel | input | 1 | 0: 4-bit exponent layout, 1: 5-bit exponent layout |
| stoch_en | input | 1 | 1: bias-add then truncate; 0: nearest-even |
| sat_en | input | 1 | 1: clamp overflow and infinity to the largest finite value |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_byte | output | 8 | 8-bit float result |

## Verification
On every cycle, the bound properties check the following:
- the one-clock valid latency and the clearing effect of reset;
- that the input sign is kept;
- the exact quiet-NaN and infinity codes;
- that no non-NaN input ever yields a NaN code, and that a saturating request never yields an infinity code.

Only the bench scenarios can show that a magnitude is numerically right. This covers tie-to-even choices, the stochastic carry that crosses into the next binade, gradual underflow into subnormals, and the exact point at which overflow starts. The bench compares these against a model in real arithmetic over a stride through all 65536 half-precision codes, in every mode combination.

// File: rtl/fp8cvt_pkg.sv
package fp8cvt_pkg;

    // Half-precision input layout
    localparam int HALF_W     = 16;
    localparam int HALF_EXP_W = 5;
    localparam int HALF_MAN_W = 10;
    localparam int HALF_BIAS  = (1 << (HALF_EXP_W - 1)) - 1;

    // Output byte and stochastic bias
    localparam int BYTE_W = 8;
    localparam int MAG_W  = BYTE_W - 1;
    localparam int RAND_W = 8;

    // The two selectable output layouts
    localparam int FMT_COUNT    = 2;
    localparam int NARROW_EXP_W = 4;
    localparam int WIDE_EXP_W   = 5;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } half_cls_e;

    typedef enum logic {
        FMT_E4M3 = 1'b0,
        FMT_E5M2 = 1'b1
    } byte_fmt_e;

    function automatic int lane_exp_w(input int idx);
        return (idx == 0) ? NARROW_EXP_W : WIDE_EXP_W;
    endfunction

endpackage

// File: rtl/fp16_field_split.sv
module fp16_field_split
    import fp8cvt_pkg::*;
(
    input  logic [HALF_W-1:0]     half_i,
    output half_cls_e             cls_o,
    output logic [HALF_MAN_W:0]   sig_o,
    output logic [HALF_EXP_W-1:0] exp_eff_o
);

    logic [HALF_EXP_W-1:0] exp_f;
    logic [HALF_MAN_W-1:0] man_f;
    logic                  exp_all1;
    logic                  exp_all0;
    logic                  man_all0;

    assign exp_f = half_i[HALF_W-2 -: HALF_EXP_W];
    assign man_f = half_i[HALF_MAN_W-1:0];

    always_comb begin
        exp_all1 = &exp_f;
        exp_all0 = ~|exp_f;
        man_all0 = ~|man_f;

        if (exp_all1) begin
            cls_o = man_all0 ? CLS_INF : CLS_NAN;
        end else if (exp_all0) begin
            cls_o = man_all0 ? CLS_ZERO : CLS_SUB;
        end else begin
            cls_o = CLS_NORM;
        end

        // Hidden bit is set only for normal encodings; subnormals share exponent 1
        sig_o     = {~exp_all0, man_f};
        exp_eff_o = exp_all0 ? HALF_EXP_W'(1) : exp_f;
    end

endmodule

// File: rtl/fp8_narrow_lane.sv
module fp8_narrow_lane
    import fp8cvt_pkg::*;
#(
    parameter int EXP_W = 4,
    parameter int MAN_W = 3
) (
    input  half_cls_e             cls_i,
    input  logic [HALF_MAN_W:0]   sig_i,
    input  logic [HALF_EXP_W-1:0] exp_eff_i,
    input  logic                  stoch_i,
    input  logic                  sat_i,
    input  logic [RAND_W-1:0]     bias_i,
    output logic [EXP_W+MAN_W-1:0] mag_o
);

    localparam int LMAG_W   = EXP_W + MAN_W;
    localparam int EXP_BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int SIG_W    = HALF_MAN_W + 1;
    localparam int BASE_SH  = HALF_MAN_W - MAN_W;
    // Deepest right shift: smallest input exponent into the target subnormal range
    localparam int MAX_SH   = BASE_SH + HALF_BIAS - EXP_BIAS;
    localparam int FRAC_W   = MAX_SH + RAND_W + 1;
    localparam int WIDE_W   = SIG_W + FRAC_W;
    localparam int SH_W     = $clog2(MAX_SH + 1) + 1;
    localparam int CODE_W   = LMAG_W + 2;

    localparam logic [CODE_W-1:0] INF_CODE = CODE_W'(((1 << EXP_W) - 1) << MAN_W);
    localparam logic [LMAG_W-1:0] INF_MAG  = LMAG_W'(((1 << EXP_W) - 1) << MAN_W);
    localparam logic [LMAG_W-1:0] MAX_MAG  = INF_MAG - LMAG_W'(1);
    localparam logic [LMAG_W-1:0] NAN_MAG  = INF_MAG | LMAG_W'(1 << (MAN_W - 1));
    localparam logic signed [7:0] TE_OFS   = 8'(EXP_BIAS - HALF_BIAS);

    logic signed [7:0]   tgt_exp;
    logic [SH_W-1:0]     rsh;
    logic [7:0]          base_exp;
    logic [WIDE_W-1:0]   shifted;
    logic [SIG_W-1:0]    kept;
    logic [FRAC_W-1:0]   dropped;
    logic                guard_b;
    logic                sticky_b;
    logic [RAND_W:0]     bias_sum;
    logic                round_up;
    logic [CODE_W-1:0]   code;
    logic                ovf;

    always_comb begin
        // Target exponent field the value would take if it stayed normal
        tgt_exp = $signed({3'b000, exp_eff_i}) + TE_OFS;

        if (tgt_exp >= 8'sd1) begin
            rsh      = SH_W'(BASE_SH);
            base_exp = 8'(tgt_exp - 8'sd1);
        end else begin
            // Below the normal range: shift further, exponent field stays zero
            rsh      = SH_W'(BASE_SH + 1) - tgt_exp[SH_W-1:0];
            base_exp = 8'd0;
        end

        shifted  = {sig_i, {FRAC_W{1'b0}}} >> rsh;
        kept     = shifted[WIDE_W-1:FRAC_W];
        dropped  = shifted[FRAC_W-1:0];
        guard_b  = dropped[FRAC_W-1];
        sticky_b = |dropped[FRAC_W-2:0];
        bias_sum = {1'b0, dropped[FRAC_W-1 -: RAND_W]} + {1'b0, bias_i};

        if (stoch_i) begin
            round_up = bias_sum[RAND_W];
        end else begin
            round_up = guard_b & (sticky_b | kept[0]);
        end

        // Hidden bit in kept adds one to the exponent field; a rounding carry ripples up
        code = (CODE_W'(base_exp) << MAN_W) + CODE_W'(kept) + CODE_W'(round_up);
        ovf  = (code >= INF_CODE);

        unique case (cls_i)
            CLS_NAN:  mag_o = NAN_MAG;
            CLS_INF:  mag_o = sat_i ? MAX_MAG : INF_MAG;
            CLS_ZERO: mag_o = '0;
            CLS_SUB,
            CLS_NORM: mag_o = ovf ? (sat_i ? MAX_MAG : INF_MAG) : code[LMAG_W-1:0];
            default:  mag_o = '0;
        endcase
    end

endmodule

// File: rtl/fp16_to_fp8_cvt.sv
module fp16_to_fp8_cvt
    import fp8cvt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [HALF_W-1:0] in_half,
    input  logic [RAND_W-1:0] in_bias,
    input  logic              fmt_sel,
    input  logic              stoch_en,
    input  logic              sat_en,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);

    half_cls_e             cls;
    logic [HALF_MAN_W:0]   sig;
    logic [HALF_EXP_W-1:0] exp_eff;
    logic [MAG_W-1:0]      lane_mag [FMT_COUNT];
    logic [MAG_W-1:0]      sel_mag;

    fp16_field_split u_split (
        .half_i    (in_half),
        .cls_o     (cls),
        .sig_o     (sig),
        .exp_eff_o (exp_eff)
    );

    for (genvar g = 0; g < FMT_COUNT; g++) begin : g_lane
        localparam int LEW = lane_exp_w(g);
        localparam int LMW = MAG_W - LEW;

        fp8_narrow_lane #(
            .EXP_W (LEW),
            .MAN_W (LMW)
        ) u_lane (
            .cls_i     (cls),
            .sig_i     (sig),
            .exp_eff_i (exp_eff),
            .stoch_i   (stoch_en),
            .sat_i     (sat_en),
            .bias_i    (in_bias),
            .mag_o     (lane_mag[g])
        );
    end

    always_comb begin
        unique case (byte_fmt_e'(fmt_sel))
            FMT_E4M3: sel_mag = lane_mag[0];
            FMT_E5M2: sel_mag = lane_mag[1];
            default:  sel_mag = lane_mag[0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_byte <= {in_half[HALF_W-1], sel_mag};
            end
        end
    end

endmodule

// File: rtl/fp8_cvt_chk.sv
module fp8_cvt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] in_half,
    input logic        fmt_sel,
    input logic        sat_en,
    input logic        out_valid,
    input logic [7:0]  out_byte
);

    logic in_nan;
    logic in_inf;

    assign in_nan = (&in_half[14:10]) && (|in_half[9:0]);
    assign in_inf = (&in_half[14:10]) && !(|in_half[9:0]);

    // R1
    lat_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R10
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_byte[7] == $past(in_half[15]));

    // R9
    quiet_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_nan |=> out_byte[6:0] == ($past(fmt_sel) ? 7'h7E : 7'h7C));

    // R8
    inf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_inf && !sat_en |=> out_byte[6:0] == ($past(fmt_sel) ? 7'h7C : 7'h78));

    // R8
    inf_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_inf && sat_en |=> out_byte[6:0] == ($past(fmt_sel) ? 7'h7B : 7'h77));

    // R7
    sat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && sat_en && !in_nan |=> out_byte[6:0] <= ($past(fmt_sel) ? 7'h7B : 7'h77));

    // R6
    no_nan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_nan |=> out_byte[6:0] <= ($past(fmt_sel) ? 7'h7C : 7'h78));

endmodule

bind fp16_to_fp8_cvt fp8_cvt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_half   (in_half),
    .fmt_sel   (fmt_sel),
    .sat_en    (sat_en),
    .out_valid (out_valid),
    .out_byte  (out_byte)
);

// File: tb/tb_fp16_to_fp8_cvt.sv
module tb_fp16_to_fp8_cvt;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = '0;
    logic [7:0]  in_bias = '0;
    logic        fmt_sel = 1'b0;
    logic        stoch_en = 1'b0;
    logic        sat_en = 1'b0;
    logic        out_valid;
    logic [7:0]  out_byte;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    logic  pend_valid = 1'b0;
    logic [7:0]  pend_byte = '0;
    logic [15:0] pend_in = '0;
    string pend_tag = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    fp16_to_fp8_cvt dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_half   (in_half),
        .in_bias   (in_bias),
        .fmt_sel   (fmt_sel),
        .stoch_en  (stoch_en),
        .sat_en    (sat_en),
        .out_valid (out_valid),
        .out_byte  (out_byte)
    );

    function automatic real p2(input int k);
        real r = 1.0;
        if (k >= 0) repeat (k) r = r * 2.0;
        else repeat (-k) r = r / 2.0;
        return r;
    endfunction

    function automatic real half_mag(input logic [15:0] h);
        int e = int'(h[14:10]);
        int m = int'(h[9:0]);
        if (e == 0) return real'(m) * p2(-24);
        return real'(1024 + m) * p2(e - 25);
    endfunction

    function automatic real byte_mag(input int c, input int ew, input int mw);
        int eb = (1 << (ew - 1)) - 1;
        int ef = c >> mw;
        int mf = c & ((1 << mw) - 1);
        if (ef == 0) return real'(mf) * p2(1 - eb - mw);
        return real'((1 << mw) + mf) * p2(ef - eb - mw);
    endfunction

    task automatic model(input logic [15:0] h, input bit f, input bit st, input bit sa,
                         input logic [7:0] b, output logic [7:0] res, output string tag);
        int  ew   = f ? 5 : 4;
        int  mw   = 7 - ew;
        int  eb   = (1 << (ew - 1)) - 1;
        int  infc = ((1 << ew) - 1) << mw;
        int  maxc = infc - 1;
        int  nanc = infc | (1 << (mw - 1));
        logic s   = h[15];
        real x, ulp, q, fl, y;
        int  p, n, c;
        tag = f ? "R3" : "R2";
        if (h[14:10] == 5'h1F && h[9:0] != 0) begin
            res = {s, 7'(nanc)}; tag = "R9"; return;
        end
        if (h[14:10] == 5'h1F) begin
            res = {s, 7'(sa ? maxc : infc)}; tag = "R8"; return;
        end
        if (h[14:10] == 0) tag = "R4";
        if (st) tag = "R5";
        x = half_mag(h);
        if (x == 0.0) begin
            res = {s, 7'd0}; return;
        end
        p = 1 - eb;
        while (x >= p2(p + 1)) p++;
        ulp = p2(p - mw);
        q   = x / ulp;
        fl  = $floor(q);
        if (st) begin
            n = int'($floor(q + real'(b) / 256.0));
        end else begin
            n = int'(fl);
            if ((q - fl > 0.5) || (q - fl == 0.5 && (n % 2) == 1)) n++;
        end
        y = real'(n) * ulp;
        if (y > byte_mag(maxc, ew, mw)) begin
            res = {s, 7'(sa ? maxc : infc)}; tag = sa ? "R7" : "R6"; return;
        end
        c = 0;
        while (c < maxc && byte_mag(c, ew, mw) != y) c++;
        if (c < (1 << mw) && !st) tag = "R4";
        res = {s, 7'(c)};
    endtask

    task automatic step(input bit r, input bit v, input logic [15:0] h, input bit f,
                        input bit st, input bit sa, input logic [7:0] b);
        logic [7:0] e;
        string t;
        @(negedge clk);
        n_vec++;
        if (out_valid !== pend_valid) begin
            n_bad++;
            $display("FAIL R1: out_valid=%b expected %b", out_valid, pend_valid);
        end else if (pend_valid && out_byte !== pend_byte) begin
            n_bad++;
            $display("FAIL %s: in=%h out=%h expected %h",
                     (out_byte[7] !== pend_byte[7]) ? "R10" : pend_tag,
                     pend_in, out_byte, pend_byte);
        end
        rst_n    = r;
        in_valid = v;
        in_half  = h;
        fmt_sel  = f;
        stoch_en = st;
        sat_en   = sa;
        in_bias  = b;
        model(h, f, st, sa, b, e, t);
        pend_valid = r & v;
        if (r & v) begin
            pend_byte = e;
            pend_tag  = t;
            pend_in   = h;
        end
    endtask

    task automatic vec(input logic [15:0] h, input bit f, input bit st, input bit sa,
                       input logic [7:0] b);
        step(1'b1, 1'b1, h, f, st, sa, b);
    endtask

    initial begin
        // R1: reset holds out_valid low, then an idle cycle after release
        repeat (3) step(1'b0, 1'b1, 16'h3C00, 1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00);

        // R2 / R3: plain values and ties
        vec(16'h3C00, 1'b0, 1'b0, 1'b0, 8'h00);
        vec(16'h3C00, 1'b1, 1'b0, 1'b0, 8'h00);
        vec(16'h3C80, 1'b1, 1'b0, 1'b0, 8'h00);
        vec(16'h3C40, 1'b0, 1'b0, 1'b0, 8'h00);
        vec(16'h3CC0, 1'b0, 1'b0, 1'b0, 8'h00);
        vec(16'h5B80, 1'b0, 1'b0, 1'b0, 8'h00);
        vec(16'h7B00, 1'b1, 1'b0, 1'b0, 8'h00);
        // R10: negative operands keep their sign
        vec(16'hBC00, 1'b0, 1'b0, 1'b0, 8'h00);
        vec(16'h8000, 1'b1, 1'b0, 1'b1, 8'h00);
        // R6 / R7: 248 and 65504 overflow
        vec(16'h5BC0, 1'b0, 1'b0, 1'b0, 8'h00);
        vec(16'hDBC0, 1'b0, 1'b0, 1'b1, 8'h00);
        vec(16'h7BFF, 1'b1, 1'b0, 1'b0, 8'h00);
        vec(16'h7BFF, 1'b1, 1'b0, 1'b1, 8'h00);
        // R8 / R9: infinities and NaNs
        vec(16'h7C00, 1'b0, 1'b0, 1'b0, 8'h00);
        vec(16'hFC00, 1'b1, 1'b0, 1'b1, 8'h00);
        vec(16'h7E00, 1'b0, 1'b0, 1'b1, 8'h00);
        vec(16'hFC01, 1'b1, 1'b0, 1'b0, 8'h00);
        // R4: subnormal boundaries
        vec(16'h1800, 1'b0, 1'b0, 1'b0, 8'h00);
        vec(16'h1400, 1'b0, 1'b0, 1'b0, 8'h00);
        vec(16'h1600, 1'b0, 1'b0, 1'b0, 8'h00);
        vec(16'h0001, 1'b1, 1'b0, 1'b0, 8'h00);
        vec(16'h03FF, 1'b1, 1'b0, 1'b0, 8'h00);
        vec(16'h0180, 1'b1, 1'b0, 1'b0, 8'h00);
        vec(16'h03FF, 1'b0, 1'b0, 1'b0, 8'h00);
        // R5: zero bias truncates, full bias carries into next binade
        vec(16'h3C40, 1'b0, 1'b1, 1'b0, 8'h00);
        vec(16'h3C40, 1'b0, 1'b1, 1'b0, 8'hFF);
        vec(16'h3FC0, 1'b0, 1'b1, 1'b0, 8'hC0);
        vec(16'h3FC0, 1'b0, 1'b1, 1'b0, 8'h7F);
        vec(16'h5B90, 1'b0, 1'b1, 1'b0, 8'hF0);
        vec(16'h5B90, 1'b0, 1'b1, 1'b1, 8'hF0);
        vec(16'h0001, 1'b1, 1'b1, 1'b0, 8'hFF);

        // R1: reset in mid-stream drops a valid operand
        step(1'b0, 1'b1, 16'h3C00, 1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b0, 16'h3C00, 1'b0, 1'b0, 1'b0, 8'h00);

        // Sweep across the code space in every mode
        for (int i = 0; i < 65536; i += 29) begin
            for (int k = 0; k < 8; k++) begin
                vec(16'(i), k[0], k[1], k[2], 8'((i * 37 + k * 91) & 255));
            end
            if (i % 7 == 0) step(1'b1, 1'b0, 16'(i), 1'b0, 1'b0, 1'b0, 8'h00);
        end

        step(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule